// File: doc/BRIEF.md
# Three-Wire Control Bus Slave

This block is the receive side of a slave on a three-wire control bus driven by a microcontroller. The bus has a mode line, a bus clock and a data line. All three are brought into the fast system clock domain through two-flop synchronisers, and their edges are found there. The bus clock may run at no more than a quarter of the system clock rate. The phase is read from the level of the mode line. With the mode line LOW, falling bus-clock edges start a header phase. With the mode line HIGH, the bus carries payload bits.

The header byte holds a six-bit operational address in bits 7..2 and a two-bit direction/option field in bits 1..0. The block has a fixed address, set by a parameter. A header carrying that address selects the slave. A header carrying the all-zero special-function address puts the slave into the interface-reset condition, whatever the two low bits hold. Any other header, or a header that does not have exactly eight bits, deselects it.

While the slave is selected, payload bits are gathered into 8-bit or 16-bit units. Each finished unit is presented on a parallel output together with a one-cycle strobe. The controller may send units back to back with the mode line held HIGH. It may also pause between units in a halt state, with the mode line LOW and the bus clock held HIGH.

The controller FSM has four states:
- IDLE is the state after reset.
- HDR is the header phase.
- PAY is the payload phase.
- HALT is the pause after payload.

Its transitions are:
- IDLE/HALT→HDR happens on a bus-clock fall while the mode line is LOW.
- IDLE/HALT→PAY happens on a mode rise, which resumes with the current selection.
- HDR→PAY happens on a mode rise, when the header is evaluated.
- PAY→HALT happens on a mode fall.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After reset, `unit_vld_o` is 0, `unit_o` is 0 and the slave is deselected, so payload sent before any header gives no strobe.
- R2: After a header whose bits 7..2 equal `OWN_ADDR` (bits 1..0 are don't-care), payload bits are sent LSB first and taken on rising bus-clock edges. Each complete 8-bit unit appears on `unit_o` with `unit_vld_o` HIGH for exactly one system cycle, three system cycles after the last rising bus-clock edge reaches the pins. `unit_o` holds its value between strobes.
- R3: With `UNIT_W` = 16, a unit is two bytes. The first byte received becomes bits 15..8 and the second becomes bits 7..0, each byte sent LSB first.
- R4: Units sent back to back with the mode line held HIGH, with no halt in between, are each delivered.
- R5: A halt (mode LOW with the bus clock HIGH) is not treated as a header. When the mode line rises again, payload continues under the same selection.
- R6: After a header whose address is non-zero and not equal to `OWN_ADDR`, no payload strobe is produced.
- R7: A header with address bits 7..2 all zero enters the interface-reset condition whatever bits 1..0 hold. In that condition all following payload gives no strobe.
- R8: A later header carrying `OWN_ADDR` leaves the interface-reset condition, and payload is accepted again.
- R9: A partial unit cut off by a mode-line transition is discarded with no strobe, and the next unit is assembled from its own first bit.
- R10: A header phase with other than eight bits deselects the slave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_mode_i | input | 1 | Bus mode line (LOW: header/halt, HIGH: payload) |
| cb_clk_i | input | 1 | Bus clock, asynchronous to `clk` |
| cb_dat_i | input | 1 | Bus data line |
| unit_o | output | UNIT_W | Last received unit |
| unit_vld_o | output | 1 | One-cycle strobe marking a new unit on `unit_o` |

## Verification
A wrong selection flag shows up at the ports as strobes that are missing or extra. This appears within three cycles of the last payload bit of the next unit. A bit counter that fails to clear, or that miscounts, shifts every later unit. The first unit after the fault then carries wrong data or a strobe in the wrong cycle. The bench therefore compares both outputs on every system clock against a model that schedules each expected strobe at its exact cycle. It also counts strobes at the end of each phase.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HDR  = 2'd1,
        S_PAY  = 2'd2,
        S_HALT = 2'd3
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = sh[STAGES-1];
    end
endmodule

// File: rtl/tw_unit_asm.sv
`timescale 1ns/1ps
module tw_unit_asm #(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_d,
    output logic [UNIT_W-1:0] unit_q,
    output logic              vld_q
);
    localparam int BYTES = UNIT_W / 8;
    localparam int CNT_W = $clog2(UNIT_W);

    logic [CNT_W-1:0]  cnt;
    logic [UNIT_W-1:0] acc, acc_nx;
    int                pos_i;

    // bit k of the stream lands in byte (BYTES-1-k/8), bit k%8: MSB byte first
    always_comb begin
        pos_i  = (BYTES - 1 - int'(cnt) / 8) * 8 + int'(cnt) % 8;
        acc_nx = acc;
        acc_nx[pos_i[CNT_W-1:0]] = bit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            acc    <= '0;
            unit_q <= '0;
            vld_q  <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
            vld_q <= 1'b0;
        end else if (bit_en) begin
            acc <= acc_nx;
            if (cnt == CNT_W'(UNIT_W - 1)) begin
                cnt    <= '0;
                unit_q <= acc_nx;
                vld_q  <= 1'b1;
            end else begin
                cnt   <= cnt + 1'b1;
                vld_q <= 1'b0;
            end
        end else begin
            vld_q <= 1'b0;
        end
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R9
    AST_UNIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> $stable(unit_q)); // R2
endmodule

// File: rtl/tw_ctrl_slave.sv
`timescale 1ns/1ps
module tw_ctrl_slave #(
    parameter int              ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] OWN_ADDR  = 6'h15,
    parameter int              UNIT_W      = 8,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cb_mode_i,
    input  logic              cb_clk_i,
    input  logic              cb_dat_i,
    output logic [UNIT_W-1:0] unit_o,
    output logic              unit_vld_o
);
    import tw_pkg::*;

    localparam int HDR_W  = ADDR_W + 2;
    localparam int HCNT_W = $clog2(HDR_W + 2);

    logic [2:0] sync_q;
    logic       m, c, d, m_q, c_q;
    logic       m_rise, m_fall, c_rise, c_fall;

    tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cb_mode_i, cb_clk_i, cb_dat_i}),
        .q_o  (sync_q)
    );
    assign {m, c, d} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            m_q <= m;
            c_q <= c;
        end
    end
    assign m_rise = m & ~m_q;
    assign m_fall = ~m & m_q;
    assign c_rise = c & ~c_q;
    assign c_fall = ~c & c_q;

    tw_state_e          st, st_nx;
    logic [HCNT_W-1:0]  hcnt;
    logic [ADDR_W-1:0]  addr_sr;
    logic               sel_q;
    logic               hdr_done, hdr_match;
    logic               asm_clr, asm_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state and datapath controls
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE, S_HALT: begin
                if (m_rise)           st_nx = S_PAY;
                else if (c_fall && !m) st_nx = S_HDR;
            end
            S_HDR:  if (m_rise) st_nx = S_PAY;
            S_PAY:  if (m_fall) st_nx = S_HALT;
        endcase
        hdr_done  = (st == S_HDR) && m_rise;
        hdr_match = (hcnt == HCNT_W'(HDR_W)) && (addr_sr == OWN_ADDR) && (addr_sr != '0);
        asm_clr   = (st != S_PAY) || m_fall;
        asm_en    = (st == S_PAY) && m && c_rise && sel_q;
    end

    // header capture: bits 1..0 skipped, bits 7..2 shifted in LSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt    <= '0;
            addr_sr <= '0;
            sel_q   <= 1'b0;
        end else begin
            if (st != S_HDR) begin
                hcnt <= '0;
            end else if (c_rise) begin
                if (hcnt >= HCNT_W'(2) && hcnt < HCNT_W'(HDR_W))
                    addr_sr <= {d, addr_sr[ADDR_W-1:1]};
                if (hcnt <= HCNT_W'(HDR_W))
                    hcnt <= hcnt + 1'b1;
            end
            if (hdr_done) sel_q <= hdr_match;
        end
    end

    tw_unit_asm #(.UNIT_W(UNIT_W)) u_asm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (asm_clr),
        .bit_en(asm_en),
        .bit_d (d),
        .unit_q(unit_o),
        .vld_q (unit_vld_o)
    );

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_vld_o |=> !unit_vld_o); // R2
    AST_HALT_NOT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALT && c) |=> (st != S_HDR)); // R5
    AST_VLD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        unit_vld_o |-> $past(sel_q)); // R6
    AST_SPECIAL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && addr_sr == '0) |=> !sel_q); // R7
    AST_SHORT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && hcnt != HCNT_W'(HDR_W)) |=> !sel_q); // R10
endmodule

// File: tb/sim_tw_ctrl_slave.sv
`timescale 1ns/1ps
module sim_tw_ctrl_slave;
    localparam logic [5:0] OWN = 6'h15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cb_mode = 1'b0, cb_clk = 1'b1, cb_dat = 1'b0;
    logic [7:0]  u8;
    logic [15:0] u16;
    logic        v8, v16;

    always #4 clk = ~clk;

    tw_ctrl_slave #(.OWN_ADDR(OWN), .UNIT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cb_mode_i(cb_mode), .cb_clk_i(cb_clk),
        .cb_dat_i(cb_dat), .unit_o(u8), .unit_vld_o(v8));
    tw_ctrl_slave #(.OWN_ADDR(OWN), .UNIT_W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .cb_mode_i(cb_mode), .cb_clk_i(cb_clk),
        .cb_dat_i(cb_dat), .unit_o(u16), .unit_vld_o(v16));

    int checks = 0, errors = 0, cyc = 0;
    logic running = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [7:0]  exp8  [int];
    logic [15:0] exp16 [int];
    logic        m_sel = 1'b0, in_pay = 1'b0;
    int          n8 = 0, n16 = 0, tot8 = 0, tot16 = 0, obs8 = 0, obs16 = 0;
    logic [7:0]  acc8;
    logic [15:0] acc16;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // per-clock comparison against the scheduled expectations
    always @(negedge clk) begin
        if (running) begin
            chk(v8 == exp8.exists(cyc), cur_req, "strobe8", int'(v8), int'(exp8.exists(cyc)));
            if (v8) begin
                obs8++;
                if (exp8.exists(cyc)) chk(u8 == exp8[cyc], cur_req, "unit8", int'(u8), int'(exp8[cyc]));
            end
            chk(v16 == exp16.exists(cyc), cur_req, "strobe16", int'(v16), int'(exp16.exists(cyc)));
            if (v16) begin
                obs16++;
                if (exp16.exists(cyc)) chk(u16 == exp16[cyc], cur_req, "unit16", int'(u16), int'(exp16[cyc]));
            end
        end
    end

    task automatic hwait();
        repeat (4) @(negedge clk);
    endtask

    task automatic mclr();
        n8 = 0; n16 = 0;
    endtask

    task automatic model_rise(input logic b);
        int p;
        if (in_pay && m_sel) begin
            acc8[n8] = b; n8++;
            if (n8 == 8) begin exp8[cyc + 3] = acc8; tot8++; n8 = 0; end
            p = (1 - n16 / 8) * 8 + n16 % 8;
            acc16[p] = b; n16++;
            if (n16 == 16) begin exp16[cyc + 3] = acc16; tot16++; n16 = 0; end
        end
    endtask

    task automatic bus_bit(input logic b);
        cb_clk = 1'b0; cb_dat = b; hwait();
        cb_clk = 1'b1; model_rise(b); hwait();
    endtask

    task automatic send_hdr(input logic [7:0] h, input int nb);
        cb_mode = 1'b0; in_pay = 1'b0; mclr(); hwait();
        for (int i = 0; i < nb; i++) bus_bit(h[i]);
        cb_mode = 1'b1;
        m_sel = (nb == 8) && (h[7:2] == OWN) && (h[7:2] != 6'd0);
        in_pay = 1'b1; mclr(); hwait();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) bus_bit(b[i]);
    endtask

    task automatic halt();
        cb_mode = 1'b0; in_pay = 1'b0; mclr(); hwait(); hwait();
    endtask

    task automatic resume();
        cb_mode = 1'b1; in_pay = 1'b1; mclr(); hwait();
    endtask

    task automatic phase_end(input string req);
        repeat (6) @(negedge clk);
        chk(obs8 == tot8, req, "count8", obs8, tot8);
        chk(obs16 == tot16, req, "count16", obs16, tot16);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(v8 == 1'b0 && u8 == 8'h00, "R1", "reset8", int'(u8), 0);
        chk(v16 == 1'b0 && u16 == 16'h0000, "R1", "reset16", int'(u16), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        running = 1'b1;

        // R1: payload before any header is ignored
        cur_req = "R1"; resume(); send_byte(8'h99); phase_end("R1");

        // R2 R3 R4: matching header (low bits 10), four bytes back to back
        cur_req = "R2"; send_hdr({OWN, 2'b10}, 8);
        send_byte(8'hA5); send_byte(8'h3C);
        cur_req = "R4"; send_byte(8'h81); send_byte(8'h7E);
        phase_end("R3");

        // R5: halt then resume keeps selection
        cur_req = "R5"; halt(); resume();
        send_byte(8'h5A); send_byte(8'h0F); phase_end("R5");

        // R6: other address
        cur_req = "R6"; send_hdr({OWN ^ 6'h01, 2'b00}, 8);
        send_byte(8'h11); send_byte(8'h22); phase_end("R6");

        // R7: special-function address with low bits 11
        cur_req = "R8"; send_hdr({OWN, 2'b01}, 8); send_byte(8'h44); send_byte(8'h45);
        cur_req = "R7"; send_hdr(8'h03, 8);
        send_byte(8'hC0); send_byte(8'hDE); halt(); resume(); send_byte(8'h12); send_byte(8'h34);
        phase_end("R7");

        // R8: matching header leaves the reset condition
        cur_req = "R8"; send_hdr({OWN, 2'b11}, 8);
        send_byte(8'hE7); send_byte(8'h18); phase_end("R8");

        // R9: partial unit cut by halt is dropped
        cur_req = "R9"; bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        halt(); resume(); send_byte(8'hC3); send_byte(8'h77); phase_end("R9");

        // R10: short header deselects
        cur_req = "R10"; send_hdr({OWN, 2'b00}, 5);
        send_byte(8'h55); send_byte(8'hAA); phase_end("R10");

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule